// File: doc/BRIEF.md
# Member Seat Ballot Latch

One instance of this block sits behind each member's desk unit in a chamber voting system. It captures three events from debounced buttons: that the member has registered as present, and a choice for or against the motion. It keeps them until the next session reset. A central sequencer elsewhere opens a registration window and a voting window as levels. This block only honours a button while the matching window is open. A choice counts only when the seat was registered on an earlier clock edge.

The four result flags come from flip-flops, so they hold still while a collator scans many seats. A seat that ends up with both choices latched casts a spoilt ballot: both choice flags read zero and the void flag is raised. A registered seat with no choice is also reported as void, because the void flag means "registered, and the for and against latches agree".

Top module: `voter_seat_latch`

## Requirements
- R1: A high `sess_rst` at a rising clock edge clears all four outputs to 0 at that edge. They stay 0 while it is held.
- R2: `seat_enrolled` becomes 1 at an edge where `acc_win` and `btn_enrol` are both 1. A press of `btn_enrol` while `acc_win` is 0 leaves it at 0.
- R3: Once `seat_enrolled` is 1, it stays 1 until the next `sess_rst`, whatever the windows and buttons do.
- R4: A press of `btn_yes` or `btn_no` is latched only at an edge where `vote_win` is 1 and the seat was registered before that edge. A press in the same edge as the registration press is ignored, as is any press on an unregistered seat or outside the voting window.
- R5: A registered seat with exactly one choice latched drives that choice's flag high, the other choice flag low and `seat_void` low.
- R6: When both choices are latched, whether in one edge or in different edges, `seat_yes` and `seat_no` are 0 and `seat_void` is 1.
- R7: A registered seat with no choice latched shows `seat_void` = 1 and both choice flags = 0.
- R8: A latched choice cannot be withdrawn. Releasing the button, closing the window or pressing nothing leaves it set until `sess_rst`; only adding the other choice changes the outputs (to R6).
- R9: With both windows low, no button press changes any output.
- R10: An unregistered seat shows all four outputs at 0.
- R11: Outputs change only at a rising clock edge. The effect of an accepted press is visible right after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sess_rst | input | 1 | Synchronous active-high session reset |
| acc_win | input | 1 | Registration window level |
| vote_win | input | 1 | Voting window level |
| btn_enrol | input | 1 | Registration button, debounced |
| btn_yes | input | 1 | For button, debounced |
| btn_no | input | 1 | Against button, debounced |
| seat_enrolled | output | 1 | Seat is registered |
| seat_yes | output | 1 | Valid vote for the motion |
| seat_no | output | 1 | Valid vote against the motion |
| seat_void | output | 1 | Registered seat with no valid single choice |

## Verification
The block holds only three state bits: registered, for-latched and against-latched. Any corruption of them shows on the outputs right after the edge that corrupts them, because the output flags are a registered image of that state. A lost choice latch makes a seat fall back from a single vote to void. A leaked latch turns a single vote into void, or raises a choice on a seat with no registration. The reference model in the bench therefore compares all four flags after every edge, so a fault is reported in the cycle it appears.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int NUM_CHOICES = 2;
  localparam int IDX_YES     = 0;
  localparam int IDX_NO      = 1;
  localparam int CNT_W       = $clog2(NUM_CHOICES + 1);

  typedef struct packed {
    logic                   enrolled;
    logic [NUM_CHOICES-1:0] pick;
  } seat_state_t;
endpackage

// File: rtl/vt_enrol_latch.sv
module vt_enrol_latch (
  input  logic clk,
  input  logic rst,
  input  logic win,
  input  logic press,
  output logic enrolled_q,
  output logic enrolled_d
);
  always_comb begin
    enrolled_d = enrolled_q;
    if (rst) begin
      enrolled_d = 1'b0;
    end else if (win && press) begin
      enrolled_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    enrolled_q <= enrolled_d;
  end
endmodule

// File: rtl/vt_choice_latch.sv
module vt_choice_latch #(
  parameter int NUM = vt_pkg::NUM_CHOICES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           win,
  input  logic           enrolled_q,
  input  logic [NUM-1:0] press,
  output logic [NUM-1:0] pick_d
);
  logic [NUM-1:0] pick_q;

  for (genvar i = 0; i < NUM; i++) begin : g_pick
    always_comb begin
      pick_d[i] = pick_q[i];
      if (rst) begin
        pick_d[i] = 1'b0;
      end else if (win && enrolled_q && press[i]) begin
        pick_d[i] = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      pick_q[i] <= pick_d[i];
    end
  end
endmodule

// File: rtl/vt_verdict.sv
module vt_verdict
  import vt_pkg::*;
(
  input  logic                   clk,
  input  seat_state_t            state_d,
  output logic                   enrolled_o,
  output logic [NUM_CHOICES-1:0] pick_o,
  output logic                   void_o
);
  logic [CNT_W-1:0]       n_picks;
  logic                   single;
  logic [NUM_CHOICES-1:0] pick_n;

  always_comb begin
    n_picks = '0;
    for (int i = 0; i < NUM_CHOICES; i++) begin
      n_picks = n_picks + CNT_W'(state_d.pick[i]);
    end
    single = (n_picks == CNT_W'(1));
    pick_n = single ? state_d.pick : '0;
  end

  always_ff @(posedge clk) begin
    enrolled_o <= state_d.enrolled;
    pick_o     <= pick_n;
    void_o     <= state_d.enrolled && !single;
  end
endmodule

// File: rtl/voter_seat_latch.sv
module voter_seat_latch
  import vt_pkg::*;
(
  input  logic clk,
  input  logic sess_rst,
  input  logic acc_win,
  input  logic vote_win,
  input  logic btn_enrol,
  input  logic btn_yes,
  input  logic btn_no,
  output logic seat_enrolled,
  output logic seat_yes,
  output logic seat_no,
  output logic seat_void
);
  logic                   enr_q;
  logic                   enr_d;
  logic [NUM_CHOICES-1:0] press;
  logic [NUM_CHOICES-1:0] pick_d;
  logic [NUM_CHOICES-1:0] pick_o;
  seat_state_t            st_d;

  always_comb begin
    press          = '0;
    press[IDX_YES] = btn_yes;
    press[IDX_NO]  = btn_no;
    st_d.enrolled  = enr_d;
    st_d.pick      = pick_d;
  end

  vt_enrol_latch u_enrol (
    .clk        (clk),
    .rst        (sess_rst),
    .win        (acc_win),
    .press      (btn_enrol),
    .enrolled_q (enr_q),
    .enrolled_d (enr_d)
  );

  vt_choice_latch #(.NUM(NUM_CHOICES)) u_choice (
    .clk        (clk),
    .rst        (sess_rst),
    .win        (vote_win),
    .enrolled_q (enr_q),
    .press      (press),
    .pick_d     (pick_d)
  );

  vt_verdict u_verdict (
    .clk        (clk),
    .state_d    (st_d),
    .enrolled_o (seat_enrolled),
    .pick_o     (pick_o),
    .void_o     (seat_void)
  );

  assign seat_yes = pick_o[IDX_YES];
  assign seat_no  = pick_o[IDX_NO];
endmodule

// File: rtl/voter_seat_chk.sv
module voter_seat_chk (
  input logic clk,
  input logic sess_rst,
  input logic acc_win,
  input logic vote_win,
  input logic btn_enrol,
  input logic btn_yes,
  input logic btn_no,
  input logic seat_enrolled,
  input logic seat_yes,
  input logic seat_no,
  input logic seat_void
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (sess_rst)
    $past(sess_rst) |-> !seat_enrolled && !seat_yes && !seat_no && !seat_void); // R1

  AST_ENROL_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (sess_rst)
    $rose(seat_enrolled) |-> $past(acc_win) && $past(btn_enrol)); // R2

  AST_ENROL_STICKY: assert property (@(posedge clk) disable iff (sess_rst)
    seat_enrolled |=> seat_enrolled); // R3

  AST_CHOICE_GATED: assert property (@(posedge clk) disable iff (sess_rst)
    (!$past(sess_rst) && ($changed(seat_yes) || $changed(seat_no)))
      |-> $past(vote_win) && $past(seat_enrolled)); // R4

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (sess_rst)
    !(seat_yes && seat_no)); // R6

  AST_VOID_EXCLUSIVE: assert property (@(posedge clk) disable iff (sess_rst)
    seat_void |-> !seat_yes && !seat_no); // R6

  AST_VOID_NEEDS_ENROL: assert property (@(posedge clk) disable iff (sess_rst)
    (seat_void || seat_yes || seat_no) |-> seat_enrolled); // R10

  AST_REG_SEAT_DECIDED: assert property (@(posedge clk) disable iff (sess_rst)
    seat_enrolled |-> $countones({seat_yes, seat_no, seat_void}) == 1); // R7

  AST_NO_WITHDRAW: assert property (@(posedge clk) disable iff (sess_rst)
    (seat_yes || seat_no) |=> (seat_yes || seat_no || seat_void)); // R8
endmodule

bind voter_seat_latch voter_seat_chk u_chk (.*);

// File: tb/sim_voter_seat_latch.sv
`timescale 1ns/1ps
module sim_voter_seat_latch;
  logic clk = 1'b0;
  logic sess_rst = 1'b1;
  logic acc_win = 1'b0;
  logic vote_win = 1'b0;
  logic btn_enrol = 1'b0;
  logic btn_yes = 1'b0;
  logic btn_no = 1'b0;
  logic seat_enrolled, seat_yes, seat_no, seat_void;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_enr = 0, m_yes = 0, m_no = 0;

  always #4 clk = ~clk;

  voter_seat_latch u0 (
    .clk(clk), .sess_rst(sess_rst), .acc_win(acc_win), .vote_win(vote_win),
    .btn_enrol(btn_enrol), .btn_yes(btn_yes), .btn_no(btn_no),
    .seat_enrolled(seat_enrolled), .seat_yes(seat_yes),
    .seat_no(seat_no), .seat_void(seat_void)
  );

  always @(posedge clk) begin
    if (sess_rst) begin
      m_enr <= 0; m_yes <= 0; m_no <= 0;
    end else begin
      if (acc_win && btn_enrol) m_enr <= 1;
      if (vote_win && m_enr && btn_yes) m_yes <= 1;
      if (vote_win && m_enr && btn_no)  m_no  <= 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    bit e_yes, e_no, e_void;
    e_yes  = m_yes && !m_no;
    e_no   = m_no && !m_yes;
    e_void = m_enr && (m_yes == m_no);
    chk(seat_enrolled, m_enr, "R11 model enrolled");
    chk(seat_yes, e_yes, "R11 model yes");
    chk(seat_no, e_no, "R11 model no");
    chk(seat_void, e_void, "R11 model void");
  endtask

  task automatic step(input bit r, input bit aw, input bit vw,
                      input bit be, input bit by, input bit bn);
    sess_rst = r; acc_win = aw; vote_win = vw;
    btn_enrol = be; btn_yes = by; btn_no = bn;
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  task automatic expect4(input bit e, input bit y, input bit n, input bit v,
                         input string tag);
    chk(seat_enrolled, e, {tag, " enrolled"});
    chk(seat_yes, y, {tag, " yes"});
    chk(seat_no, n, {tag, " no"});
    chk(seat_void, v, {tag, " void"});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 1);
    expect4(0, 0, 0, 0, "R1 reset held");

    // R9: presses with no window
    step(0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 1, 0, 1);
    expect4(0, 0, 0, 0, "R9 no window");

    // R4/R10: votes on an unregistered seat
    step(0, 0, 1, 0, 1, 0);
    step(0, 0, 1, 0, 0, 1);
    expect4(0, 0, 0, 0, "R10 unregistered vote");

    // R2 negative: enrol press outside window
    step(0, 0, 1, 1, 0, 0);
    chk(seat_enrolled, 1'b0, "R2 enrol outside window");

    // R4: registration and vote in the same edge
    step(0, 1, 1, 1, 1, 0);
    expect4(1, 0, 0, 1, "R4 same-edge vote ignored");
    // R7: registered, no choice
    step(0, 0, 0, 0, 0, 0);
    expect4(1, 0, 0, 1, "R7 registered no choice");
    // R3: stays registered with windows toggling
    for (int i = 0; i < 4; i++) step(0, i[0], 0, 0, 0, 0);
    chk(seat_enrolled, 1'b1, "R3 sticky");

    // R4 negative: registered, vote outside window
    step(0, 0, 0, 0, 1, 0);
    expect4(1, 0, 0, 1, "R4 vote outside window");
    // R5: single yes
    step(0, 0, 1, 0, 1, 0);
    expect4(1, 1, 0, 0, "R5 single yes");
    // R8: release and wait
    for (int i = 0; i < 3; i++) step(0, 0, i[0], 0, 0, 0);
    expect4(1, 1, 0, 0, "R8 no withdraw");
    // R9: against press with windows closed
    step(0, 0, 0, 0, 0, 1);
    expect4(1, 1, 0, 0, "R9 closed no press");
    // R6: against added later
    step(0, 0, 1, 0, 0, 1);
    expect4(1, 0, 0, 1, "R6 double vote later");
    step(0, 0, 1, 0, 1, 0);
    expect4(1, 0, 0, 1, "R6 stays void");

    // R1: reset clears a full state
    step(1, 0, 0, 0, 0, 0);
    expect4(0, 0, 0, 0, "R1 reset clears");

    // R2: enrol, then single no (R5)
    step(0, 1, 0, 1, 0, 0);
    chk(seat_enrolled, 1'b1, "R2 enrol in window");
    step(0, 0, 1, 0, 0, 1);
    expect4(1, 0, 1, 0, "R5 single no");
    step(0, 0, 1, 0, 0, 0);
    expect4(1, 0, 1, 0, "R8 no held");

    // R6: both in one edge
    step(1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 1, 1);
    expect4(1, 0, 0, 1, "R6 both same edge");

    // mixed sweep compared against the model every edge
    for (int i = 0; i < 64; i++) begin
      step((i % 23) == 22, i[1], i[2], i[3], i[4] & i[0], i[5] & ~i[0]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule